// File: doc/BRIEF.md
# E3 Maintenance Byte Alarm Validator

This block sits on the receive side of an E3 link that carries the maintenance-and-adaptation overhead byte once per frame. A framer upstream presents that byte together with a one-cycle frame strobe. The block pulls three fields out of the byte: the far-end receive failure (FERF) indication, the three-bit payload type and the timing marker. The payload type is simply latched on every frame.

The FERF bit and the timing marker are single-bit alarms, and a single corrupted frame must not make them toggle. Each of them goes through a persistence filter. The filter accepts a new value only after that value has been seen in an unbroken run of consecutive frames. A configuration input sets the run length to either 3 or 5 frames. The accepted values are held as status outputs.

Any change in the accepted FERF value sets a sticky interrupt flag. Software clears the flag with a one-cycle pulse. An enable input gates the flag onto the interrupt line.

Top module: `e3ma_alarm_validator`

## Requirements
- R1: Field positions in `ma_byte`: FERF is bit 7, the payload type is bits 5:3 and the timing marker is bit 0. `ferf_status` becomes 1 at the clock edge of the N-th consecutive valid frame whose FERF bit is 1. N is 3 when `five_frame_mode`=0 and 5 when it is 1.
- R2: `ferf_status` returns to 0 at the edge of the N-th consecutive valid frame whose FERF bit is 0.
- R3: A valid frame whose bit differs from the current run starts a new run of length 1. Frames seen before the break never count toward N.
- R4: `ferf_irq_flag` is set at the edge where `ferf_status` changes value, and only then. Repeated frames that confirm the current status do not set it.
- R5: `ferf_irq_flag` stays set until a cycle with `irq_clear`=1 and no new change. When a change and `irq_clear` fall on the same edge, the flag is left set.
- R6: `ferf_irq` equals `ferf_irq_flag` AND `irq_enable`. `irq_enable` does not affect the flag.
- R7: `payload_type` takes `ma_byte[5:3]` at the edge of every valid frame and holds it between frames.
- R8: `tm_status` accepts the timing marker under the same N-frame rule as FERF. `tm_consistent` is 1 while the current timing-marker run is at least N frames long.
- R9: Cycles with `frame_valid`=0 change no output and no run state, whatever `ma_byte` carries.
- R10: After reset every status output, the flag and `payload_type` are 0, and every run is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe: `ma_byte` holds this frame's byte |
| ma_byte | input | 8 | Maintenance-and-adaptation overhead byte |
| five_frame_mode | input | 1 | Persistence length: 0 gives 3 frames, 1 gives 5 frames |
| irq_enable | input | 1 | Gates the interrupt flag onto `ferf_irq` |
| irq_clear | input | 1 | One-cycle pulse that clears the interrupt flag |
| ferf_status | output | 1 | Validated FERF value |
| ferf_consistent | output | 1 | Current FERF run has reached N frames |
| tm_status | output | 1 | Validated timing marker value |
| tm_consistent | output | 1 | Current timing-marker run has reached N frames |
| payload_type | output | 3 | Payload type taken from the latest valid frame |
| ferf_irq_flag | output | 1 | Sticky flag: validated FERF has changed |
| ferf_irq | output | 1 | Masked interrupt |

## Verification
The bench feeds runs that stop one frame short of N in both modes. A filter with an off-by-one threshold would then accept an alarm too early or too late. It also breaks a run just before it completes, which catches a counter that keeps its count across a break instead of restarting at 1. It repeats confirming frames after acceptance and holds `ma_byte` busy while the strobe is low, so that a spurious interrupt or a count taken on strobe-less cycles becomes visible. It drives a clear pulse on the same edge as a status change, where a design that lets the clear win would lose the interrupt.

// File: rtl/e3ma_pkg.sv
package e3ma_pkg;
  localparam int unsigned MA_W     = 8;
  localparam int unsigned FERF_POS = 7;
  localparam int unsigned PT_HI    = 5;
  localparam int unsigned PT_LO    = 3;
  localparam int unsigned TM_POS   = 0;
  localparam int unsigned PT_W     = PT_HI - PT_LO + 1;
  localparam int unsigned SHORT_RUN = 3;
  localparam int unsigned LONG_RUN  = 5;

  // Channel indices of the persistence filters
  localparam int unsigned CH_FERF = 0;
  localparam int unsigned CH_TM   = 1;
  localparam int unsigned NUM_CH  = 2;

  // Required run length for the selected mode
  function automatic int unsigned persist_len(input logic five,
                                              input int unsigned short_n,
                                              input int unsigned long_n);
    return five ? long_n : short_n;
  endfunction

  // Run length after one more frame: extend a matching run (saturating), else restart at 1
  function automatic int unsigned next_run(input logic same,
                                           input int unsigned cur,
                                           input int unsigned cap);
    if (same && (cur != 0))
      return (cur >= cap) ? cap : cur + 1;
    return 1;
  endfunction
endpackage

// File: rtl/e3ma_persist_filter.sv
module e3ma_persist_filter
  import e3ma_pkg::*;
#(
  parameter int unsigned SHORT_N = 3,
  parameter int unsigned LONG_N  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic bit_in,
  input  logic five_mode,
  output logic validated,
  output logic run_ok,
  output logic change_evt
);
  localparam int unsigned CNT_W = $clog2(LONG_N + 1);

  logic             run_bit_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] thr_c;
  logic             val_q;
  logic             val_d;
  logic             same_c;
  logic             reached_c;

  always_comb begin
    thr_c     = CNT_W'(persist_len(five_mode, SHORT_N, LONG_N));
    same_c    = (bit_in == run_bit_q);
    cnt_d     = CNT_W'(next_run(same_c, 32'(cnt_q), LONG_N));
    reached_c = sample_en && (cnt_d >= thr_c);
    val_d     = reached_c ? bit_in : val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_bit_q <= 1'b0;
      cnt_q     <= '0;
      val_q     <= 1'b0;
    end else begin
      if (sample_en) begin
        run_bit_q <= bit_in;
        cnt_q     <= cnt_d;
      end
      val_q <= val_d;
    end
  end

  assign validated  = val_q;
  assign run_ok     = (cnt_q >= thr_c);
  assign change_evt = (val_d != val_q);

  // R9: no strobe, no movement
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(cnt_q) && $stable(val_q)));

  // R3: a differing bit restarts the run at one
  assert_run_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && (bit_in != run_bit_q)) |=> (cnt_q == CNT_W'(1)));

  // R1/R2: the validated value only moves on a frame, and then to that frame's bit
  assert_val_on_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(val_q) |-> ($past(sample_en) && (val_q == $past(bit_in))));

  // R10: the run counter never passes the long window
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LONG_N));
endmodule

// File: rtl/e3ma_irq_latch.sv
module e3ma_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  input  logic en,
  output logic flag,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (set_evt)
      flag_q <= 1'b1;
    else if (clr)
      flag_q <= 1'b0;
  end

  assign flag = flag_q;
  assign irq  = flag_q & en;

  // R5: sticky without a clear
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  // R4/R5: a change always leaves the flag set, clear or not
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);

  // R4: the flag only rises on a change
  assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_evt));
endmodule

// File: rtl/e3ma_field_capture.sv
module e3ma_field_capture #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (load) q_r <= din;
  end

  assign q = q_r;

  // R7: the field follows the latest valid frame
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q_r == $past(din)));
endmodule

// File: rtl/e3ma_alarm_validator.sv
module e3ma_alarm_validator
  import e3ma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_valid,
  input  logic [7:0]      ma_byte,
  input  logic            five_frame_mode,
  input  logic            irq_enable,
  input  logic            irq_clear,
  output logic            ferf_status,
  output logic            ferf_consistent,
  output logic            tm_status,
  output logic            tm_consistent,
  output logic [2:0]      payload_type,
  output logic            ferf_irq_flag,
  output logic            ferf_irq
);
  logic [NUM_CH-1:0] ch_bit;
  logic [NUM_CH-1:0] ch_val;
  logic [NUM_CH-1:0] ch_ok;
  logic [NUM_CH-1:0] ch_chg;

  assign ch_bit[CH_FERF] = ma_byte[FERF_POS];
  assign ch_bit[CH_TM]   = ma_byte[TM_POS];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_filt
    e3ma_persist_filter #(
      .SHORT_N (SHORT_RUN),
      .LONG_N  (LONG_RUN)
    ) u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_en  (frame_valid),
      .bit_in     (ch_bit[g]),
      .five_mode  (five_frame_mode),
      .validated  (ch_val[g]),
      .run_ok     (ch_ok[g]),
      .change_evt (ch_chg[g])
    );
  end

  e3ma_field_capture #(.W(PT_W)) u_pt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (frame_valid),
    .din   (ma_byte[PT_HI:PT_LO]),
    .q     (payload_type)
  );

  e3ma_irq_latch u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (ch_chg[CH_FERF]),
    .clr     (irq_clear),
    .en      (irq_enable),
    .flag    (ferf_irq_flag),
    .irq     (ferf_irq)
  );

  assign ferf_status     = ch_val[CH_FERF];
  assign ferf_consistent = ch_ok[CH_FERF];
  assign tm_status       = ch_val[CH_TM];
  assign tm_consistent   = ch_ok[CH_TM];

  // R4: status and flag move together on a change
  assert_flag_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ferf_status) |-> ferf_irq_flag);

  // R9: idle cycles leave the captured field alone
  assert_pt_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> $stable(payload_type));
endmodule

// File: tb/tb_e3ma_alarm_validator.sv
module tb_e3ma_alarm_validator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_valid = 1'b0;
  logic [7:0] ma_byte = 8'h00;
  logic       five_frame_mode = 1'b0;
  logic       irq_enable = 1'b1;
  logic       irq_clear = 1'b0;
  logic       ferf_status, ferf_consistent, tm_status, tm_consistent;
  logic [2:0] payload_type;
  logic       ferf_irq_flag, ferf_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench-side model: bit history per alarm since reset
  logic [7:0] h_ferf, h_tm;
  int         seen;
  logic       m_ferf, m_tm, m_flag;
  logic [2:0] m_pt;

  always #5 clk = ~clk;

  e3ma_alarm_validator dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .ma_byte(ma_byte),
    .five_frame_mode(five_frame_mode), .irq_enable(irq_enable), .irq_clear(irq_clear),
    .ferf_status(ferf_status), .ferf_consistent(ferf_consistent),
    .tm_status(tm_status), .tm_consistent(tm_consistent),
    .payload_type(payload_type), .ferf_irq_flag(ferf_irq_flag), .ferf_irq(ferf_irq)
  );

  function automatic logic [7:0] mk(input logic f, input logic [2:0] pt, input logic tm);
    return {f, 1'b0, pt, 2'b00, tm};
  endfunction

  function automatic int win();
    return five_frame_mode ? 5 : 3;
  endfunction

  // true when the last n history bits all equal the newest one
  function automatic logic run_full(input logic [7:0] h, input int n, input int s);
    if (s < n) return 1'b0;
    for (int i = 1; i < n; i++) if (h[i] != h[0]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " ferf_status"}, 32'(ferf_status), 32'(m_ferf));
    chk({req, " tm_status"}, 32'(tm_status), 32'(m_tm));
    chk({req, " ferf_consistent"}, 32'(ferf_consistent), 32'(run_full(h_ferf, win(), seen)));
    chk({req, " tm_consistent"}, 32'(tm_consistent), 32'(run_full(h_tm, win(), seen)));
    chk({req, " payload_type"}, 32'(payload_type), 32'(m_pt));
    chk({req, " flag"}, 32'(ferf_irq_flag), 32'(m_flag));
    chk({req, " irq"}, 32'(ferf_irq), 32'(m_flag & irq_enable));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; frame_valid = 1'b0; irq_clear = 1'b0;
    h_ferf = '0; h_tm = '0; seen = 0;
    m_ferf = 0; m_tm = 0; m_flag = 0; m_pt = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one valid frame, optional clear on the same edge; model updated after the edge
  task automatic frame(input logic [7:0] b, input logic clr);
    logic old;
    @(negedge clk);
    frame_valid = 1'b1; ma_byte = b; irq_clear = clr;
    @(negedge clk);
    frame_valid = 1'b0; irq_clear = 1'b0; ma_byte = ~b;
    h_ferf = {h_ferf[6:0], b[7]};
    h_tm   = {h_tm[6:0], b[0]};
    seen++;
    m_pt = b[5:3];
    old = m_ferf;
    if (run_full(h_ferf, win(), seen)) m_ferf = h_ferf[0];
    if (run_full(h_tm, win(), seen))   m_tm   = h_tm[0];
    if (old != m_ferf) m_flag = 1'b1;
    else if (clr)      m_flag = 1'b0;
  endtask

  task automatic clear_pulse();
    @(negedge clk); irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
    m_flag = 1'b0;
  endtask

  // R10
  task automatic t_reset();
    do_reset();
    chk("R10 reset ferf", 32'(ferf_status), 0);
    chk("R10 reset tm", 32'(tm_status), 0);
    chk("R10 reset pt", 32'(payload_type), 0);
    chk("R10 reset flag", 32'(ferf_irq_flag), 0);
    chk("R10 reset consistent", 32'({ferf_consistent, tm_consistent}), 0);
  endtask

  // R1, R2 in three-frame mode
  task automatic t_short_window();
    do_reset(); five_frame_mode = 0;
    frame(mk(1, 3'd1, 0), 0); frame(mk(1, 3'd1, 0), 0);
    chk("R1 two ones not enough", 32'(ferf_status), 0);
    frame(mk(1, 3'd1, 0), 0);
    chk("R1 third one sets", 32'(ferf_status), 1);
    chk("R4 flag on set", 32'(ferf_irq_flag), 1);
    clear_pulse();
    frame(mk(0, 3'd1, 0), 0); frame(mk(0, 3'd1, 0), 0);
    chk("R2 two zeros keep", 32'(ferf_status), 1);
    frame(mk(0, 3'd1, 0), 0);
    chk("R2 third zero clears", 32'(ferf_status), 0);
    chk_all("R2");
  endtask

  // R1 in five-frame mode
  task automatic t_long_window();
    do_reset(); five_frame_mode = 1;
    for (int i = 0; i < 4; i++) frame(mk(1, 3'd2, 1), 0);
    chk("R1 four ones in long mode", 32'(ferf_status), 0);
    chk("R8 four tm in long mode", 32'(tm_consistent), 0);
    frame(mk(1, 3'd2, 1), 0);
    chk("R1 fifth one sets", 32'(ferf_status), 1);
    chk("R8 fifth tm consistent", 32'(tm_consistent), 1);
    chk("R8 tm accepted", 32'(tm_status), 1);
    five_frame_mode = 0;
  endtask

  // R3
  task automatic t_restart();
    do_reset(); five_frame_mode = 0;
    frame(mk(1, 0, 0), 0); frame(mk(1, 0, 0), 0); frame(mk(0, 0, 0), 0);
    frame(mk(1, 0, 0), 0); frame(mk(1, 0, 0), 0);
    chk("R3 broken run not accepted", 32'(ferf_status), 0);
    frame(mk(1, 0, 0), 0);
    chk("R3 fresh run of three accepted", 32'(ferf_status), 1);
    chk_all("R3");
  endtask

  // R4, R5, R6
  task automatic t_irq();
    do_reset(); five_frame_mode = 0; irq_enable = 1;
    for (int i = 0; i < 3; i++) frame(mk(1, 0, 0), 0);
    clear_pulse();
    chk("R5 clear drops flag", 32'(ferf_irq_flag), 0);
    for (int i = 0; i < 4; i++) frame(mk(1, 0, 0), 0);
    chk("R4 confirming frames no flag", 32'(ferf_irq_flag), 0);
    irq_enable = 0;
    for (int i = 0; i < 3; i++) frame(mk(0, 0, 0), 0);
    chk("R6 masked irq low", 32'(ferf_irq), 0);
    chk("R6 flag set while masked", 32'(ferf_irq_flag), 1);
    repeat (5) @(negedge clk);
    chk("R5 flag sticky", 32'(ferf_irq_flag), 1);
    irq_enable = 1; #1;
    chk("R6 enable shows irq", 32'(ferf_irq), 1);
    clear_pulse();
    frame(mk(1, 0, 0), 0); frame(mk(1, 0, 0), 0);
    frame(mk(1, 0, 0), 1);
    chk("R5 change beats clear", 32'(ferf_irq_flag), 1);
    chk_all("R5");
  endtask

  // R7, R9
  task automatic t_payload_idle();
    do_reset(); five_frame_mode = 0;
    for (int p = 0; p < 8; p++) begin
      frame(mk(0, 3'(p), 0), 0);
      chk("R7 payload captured", 32'(payload_type), 32'(p));
    end
    frame(mk(1, 3'd6, 1), 0); frame(mk(1, 3'd6, 1), 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); ma_byte = mk(1, 3'd1, 1);
    end
    @(negedge clk);
    chk_all("R9 idle bytes ignored");
    frame(mk(0, 3'd6, 0), 0);
    chk("R9 idle did not extend run", 32'(ferf_status), 0);
  endtask

  // R8 plus mixed traffic against the model
  task automatic t_mixed();
    logic [7:0] pat;
    do_reset();
    pat = 8'b1011_0011;
    for (int i = 0; i < 60; i++) begin
      five_frame_mode = (i >= 30);
      frame(mk(pat[i % 8] ^ (i > 40), 3'(i), (i / 4) % 2 == 1), (i % 11) == 0);
      chk_all("R8 mixed traffic");
    end
  endtask

  initial begin
    t_reset();
    t_short_window();
    t_long_window();
    t_restart();
    t_irq();
    t_payload_idle();
    t_mixed();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule